// File: doc/BRIEF.md
# Intra-Set Write Restriction Controller

This controller spreads write wear across the ways of a 16-way non-volatile last-level cache. Time is split into intervals, each a fixed number of cycle ticks. For each interval one window of four adjacent ways is barred from taking writes. The next barred window is chosen at every interval boundary. In rotating mode the choice steps through the windows in turn. In counting mode it is the window that received the most writes during the interval that just ended.

The cache pipeline presents each access with its set, hit way, direction and the valid bits of the addressed set. Most accesses are answered one cycle later with the way that should be used. A write hit that lands in the barred window is steered to another way. That is the lowest invalid way outside the window or, if none exists, the lowest way outside the window after the replacement logic has evicted it. The response then tells the cache to move the block and to invalidate the original copy.

The tag array, data array, swap buffer and replacement policy sit outside this block. They talk to it only through the request, eviction and response ports.

Top module: `wr_restrict_ctrl`

## Requirements
- R1: After reset the barred window is window 0, so `restrict_mask` is 0x000F. `req_ready` is 1, and `resp_valid` and `evict_req` are 0.
- R2: An accepted read is answered one cycle later: `resp_valid`=1, `resp_way` equals the request way, and `resp_move`=0. This holds even when the way is in the barred window.
- R3: An accepted write to a way outside the barred window is answered one cycle later on the same way, with `resp_move`=0.
- R4: An accepted write whose way lies in the barred window, when the set has an invalid way outside that window, is answered one cycle later. `resp_way` is the lowest-numbered such invalid way, `resp_move`=1, and `resp_src_way` is the original way, which must be invalidated. Way w belongs to window w/4.
- R5: If no way outside the barred window is invalid, `evict_req` rises one cycle after acceptance. It carries the set and the lowest-numbered way outside the window, and it holds until `evict_ack`. The response follows one cycle after the acknowledge, naming that way with `resp_move`=1.
- R6: The interval ends on the INTERVAL-th `tick` since the last boundary. The barred window changes only then, and the new mask is visible one cycle after that tick.
- R7: With `mode_dyn`=0 at the boundary, the barred window advances from w to (w+1) mod 4.
- R8: With `mode_dyn`=1 at the boundary, the new window is the one whose counter is highest. A counter counts completed writes whose destination way lies in that window. Ties go to the lowest window index.
- R9: All window counters return to zero at each boundary. A write that completes in the boundary cycle is not counted.
- R10: A window counter stops at its maximum value (2^CNT_W - 1) instead of wrapping.
- R11: While an eviction is pending, `req_ready` is 0 and any presented request is neither answered nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dyn | input | 1 | Selection at a boundary: 0 rotates, 1 uses write counts |
| tick | input | 1 | One pulse per elapsed cycle of the interval timer |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 for a write hit (writeback or exclusive put), 0 for a read |
| req_set | input | SET_W | Set index of the access |
| req_way | input | log2(WAYS) | Hit way of the access |
| set_valid | input | WAYS | Valid bits of the addressed set |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| evict_ack | input | 1 | Replacement logic has freed the requested way |
| evict_req | output | 1 | Eviction wanted for evict_set / evict_way |
| evict_set | output | SET_W | Set of the pending eviction |
| evict_way | output | log2(WAYS) | Way to be freed |
| resp_valid | output | 1 | Response present for one cycle |
| resp_write | output | 1 | Response belongs to a write |
| resp_set | output | SET_W | Set of the response |
| resp_way | output | log2(WAYS) | Way that serves the access |
| resp_move | output | 1 | Write relocated: move block and invalidate resp_src_way |
| resp_src_way | output | log2(WAYS) | Original hit way of the access |
| restrict_mask | output | WAYS | One bit per way of the barred window |

## Verification
A read or a write that resolves at once has its response due exactly one cycle after the edge that accepts it. A relocation that needs an eviction raises `evict_req` one cycle after acceptance and answers one cycle after the acknowledge. The new mask is due one cycle after the boundary tick. The bench drives each cycle's inputs just after a rising edge and predicts the outputs for the next edge from its own model of window, counters and pending eviction. It compares every output one time unit after that edge, so every result is checked in the cycle it becomes due and not later.

// File: rtl/wr_restrict_ctrl.sv
module wr_restrict_ctrl #(
  parameter int WAYS     = 16,
  parameter int WIN_WAYS = 4,
  parameter int SET_W    = 10,
  parameter int CNT_W    = 13,
  parameter int INTERVAL = 1000000,
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_dyn,
  input  logic             tick,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [SET_W-1:0] req_set,
  input  logic [WAY_W-1:0] req_way,
  input  logic [WAYS-1:0]  set_valid,
  output logic             req_ready,
  input  logic             evict_ack,
  output logic             evict_req,
  output logic [SET_W-1:0] evict_set,
  output logic [WAY_W-1:0] evict_way,
  output logic             resp_valid,
  output logic             resp_write,
  output logic [SET_W-1:0] resp_set,
  output logic [WAY_W-1:0] resp_way,
  output logic             resp_move,
  output logic [WAY_W-1:0] resp_src_way,
  output logic [WAYS-1:0]  restrict_mask
);
  localparam int NWIN  = WAYS / WIN_WAYS;
  localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int IC_W  = $clog2(INTERVAL + 1);

  function automatic logic [WIN_W-1:0] win_of(input logic [WAY_W-1:0] w);
    return WIN_W'(w / WAY_W'(WIN_WAYS));
  endfunction

  logic [WIN_W-1:0]            rwin, nxt_dyn, nxt_rot, nxt_win, dwin;
  logic [NWIN-1:0][CNT_W-1:0]  wcnt;
  logic [CNT_W-1:0]            best;
  logic [IC_W-1:0]             icnt;
  logic                        waiting, accept, hit_restr, free_found, done, boundary, dest_write;
  logic [WAY_W-1:0]            free_way, alt_way, dest_way, pend_src;

  assign req_ready  = !waiting;
  assign evict_req  = waiting;
  assign accept     = req_valid && req_ready;
  assign hit_restr  = req_write && (win_of(req_way) == rwin);
  assign alt_way    = (rwin == '0) ? WAY_W'(WIN_WAYS) : '0;
  assign done       = (accept && !(hit_restr && !free_found)) || (waiting && evict_ack);
  assign dest_way   = waiting ? evict_way : (hit_restr ? free_way : req_way);
  assign dest_write = waiting || req_write;
  assign dwin       = win_of(dest_way);
  assign boundary   = tick && (icnt == IC_W'(INTERVAL - 1));
  assign nxt_rot    = (rwin == WIN_W'(NWIN - 1)) ? '0 : rwin + 1'b1;
  assign nxt_win    = mode_dyn ? nxt_dyn : nxt_rot;

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!set_valid[i] && win_of(WAY_W'(i)) != rwin) begin
        free_found = 1'b1;
        free_way   = WAY_W'(i);
      end
    end
  end

  always_comb begin
    best    = wcnt[0];
    nxt_dyn = '0;
    for (int i = 1; i < NWIN; i++) begin
      if (wcnt[i] > best) begin
        best    = wcnt[i];
        nxt_dyn = WIN_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < WAYS; i++) restrict_mask[i] = (win_of(WAY_W'(i)) == rwin);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rwin         <= '0;
      wcnt         <= '0;
      icnt         <= '0;
      waiting      <= 1'b0;
      evict_set    <= '0;
      evict_way    <= '0;
      pend_src     <= '0;
      resp_valid   <= 1'b0;
      resp_write   <= 1'b0;
      resp_set     <= '0;
      resp_way     <= '0;
      resp_move    <= 1'b0;
      resp_src_way <= '0;
    end else begin
      resp_valid <= done;
      if (done) begin
        resp_way     <= dest_way;
        resp_write   <= dest_write;
        resp_move    <= waiting || hit_restr;
        resp_src_way <= waiting ? pend_src : req_way;
        resp_set     <= waiting ? evict_set : req_set;
      end
      if (accept && hit_restr && !free_found) begin
        waiting   <= 1'b1;
        evict_way <= alt_way;
        evict_set <= req_set;
        pend_src  <= req_way;
      end else if (waiting && evict_ack) begin
        waiting <= 1'b0;
      end
      if (tick) icnt <= boundary ? '0 : icnt + 1'b1;
      if (boundary) begin
        rwin <= nxt_win;
        wcnt <= '0;
      end else if (done && dest_write && wcnt[dwin] != '1) begin
        wcnt[dwin] <= wcnt[dwin] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wr_restrict_ctrl_chk.sv
module wr_restrict_ctrl_chk #(
  parameter int WAYS     = 16,
  parameter int WIN_WAYS = 4,
  parameter int SET_W    = 10,
  localparam int WAY_W   = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             req_valid,
  input logic             req_ready,
  input logic             evict_ack,
  input logic             evict_req,
  input logic [WAY_W-1:0] evict_way,
  input logic             resp_valid,
  input logic             resp_write,
  input logic             resp_move,
  input logic [WAY_W-1:0] resp_way,
  input logic [WAY_W-1:0] resp_src_way,
  input logic [WAYS-1:0]  restrict_mask
);
  AST_MASK_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(restrict_mask) == WIN_WAYS); // R6
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(restrict_mask)); // R6
  AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || $past(evict_req && evict_ack))); // R2
  AST_READ_NOT_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_write |-> !resp_move); // R2
  AST_MOVE_LEAVES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_move |-> (resp_way / WIN_WAYS) != (resp_src_way / WIN_WAYS)); // R4
  AST_EVICT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    evict_req && !evict_ack |=> evict_req && $stable(evict_way)); // R5
  AST_STALL_WHILE_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    evict_req |-> !req_ready); // R11
endmodule

bind wr_restrict_ctrl wr_restrict_ctrl_chk #(.WAYS(WAYS), .WIN_WAYS(WIN_WAYS), .SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid), .req_ready(req_ready),
  .evict_ack(evict_ack), .evict_req(evict_req), .evict_way(evict_way),
  .resp_valid(resp_valid), .resp_write(resp_write), .resp_move(resp_move),
  .resp_way(resp_way), .resp_src_way(resp_src_way), .restrict_mask(restrict_mask)
);

// File: tb/wr_restrict_ctrl_tb.sv
module wr_restrict_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IVL = 8;
  localparam int CW  = 4;

  logic clk = 0, rst_n = 0, mode_dyn = 0, tick = 0;
  logic req_valid = 0, req_write = 0, evict_ack = 0;
  logic [9:0] req_set = 0;
  logic [3:0] req_way = 0;
  logic [15:0] set_valid = '1;
  logic req_ready, evict_req, resp_valid, resp_write, resp_move;
  logic [9:0] evict_set, resp_set;
  logic [3:0] evict_way, resp_way, resp_src_way;
  logic [15:0] restrict_mask;

  int checks = 0, failures = 0;

  int m_rwin = 0, m_icnt = 0;
  int m_cnt [4];
  bit m_wait = 0;
  logic [3:0] m_evway = 0, m_src = 0;
  logic [9:0] m_evset = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_restrict_ctrl #(.INTERVAL(IVL), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_dyn(mode_dyn), .tick(tick),
    .req_valid(req_valid), .req_write(req_write), .req_set(req_set), .req_way(req_way),
    .set_valid(set_valid), .req_ready(req_ready), .evict_ack(evict_ack),
    .evict_req(evict_req), .evict_set(evict_set), .evict_way(evict_way),
    .resp_valid(resp_valid), .resp_write(resp_write), .resp_set(resp_set),
    .resp_way(resp_way), .resp_move(resp_move), .resp_src_way(resp_src_way),
    .restrict_mask(restrict_mask));

  function automatic logic [15:0] mask_of(int w);
    return 16'hF << (4 * w);
  endfunction

  function automatic logic [4:0] pick_free(logic [15:0] vb, int rw);
    for (int i = 0; i < 16; i++) if (!vb[i] && (i / 4) != rw) return {1'b1, 4'(i)};
    return 5'd0;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit w, logic [9:0] s, logic [3:0] way, logic [15:0] vb, bit tk, bit ack);
    bit acc, hr, dn, bnd, e_wr, e_mv, old_wait;
    logic [4:0] fr;
    logic [3:0] e_way, e_src;
    logic [9:0] e_set;
    string tag;
    old_wait = m_wait;
    acc = v && !m_wait;
    hr  = w && (int'(way) / 4 == m_rwin);
    fr  = pick_free(vb, m_rwin);
    dn  = (acc && !(hr && !fr[4])) || (m_wait && ack);
    e_way = m_wait ? m_evway : (hr ? fr[3:0] : way);
    e_wr  = m_wait || w;
    e_mv  = m_wait || hr;
    e_src = m_wait ? m_src : way;
    e_set = m_wait ? m_evset : s;
    if (old_wait) tag = ack ? "R5" : "R11";
    else if (acc && hr) tag = fr[4] ? "R4" : "R5";
    else if (acc && w) tag = "R3";
    else if (acc) tag = "R2";
    else tag = "R6";
    if (acc && hr && !fr[4]) begin
      m_wait = 1; m_evway = (m_rwin == 0) ? 4'd4 : 4'd0; m_evset = s; m_src = way;
    end else if (m_wait && ack) m_wait = 0;
    bnd = tk && (m_icnt == IVL - 1);
    if (tk) m_icnt = bnd ? 0 : m_icnt + 1;
    if (bnd) begin
      if (mode_dyn) begin
        int b = 0;
        for (int i = 1; i < 4; i++) if (m_cnt[i] > m_cnt[b]) b = i;
        m_rwin = b;
        tag = "R8";
      end else begin
        m_rwin = (m_rwin + 1) % 4;
        tag = "R7";
      end
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    end else if (dn && e_wr) begin
      if (m_cnt[int'(e_way) / 4] < (1 << CW) - 1) m_cnt[int'(e_way) / 4]++;
    end
    req_valid = v; req_write = w; req_set = s; req_way = way; set_valid = vb; tick = tk; evict_ack = ack;
    @(posedge clk); #1;
    check(resp_valid == dn, tag, 64'(resp_valid), 64'(dn));
    if (dn)
      check({resp_way, resp_src_way, resp_set, resp_move, resp_write} == {e_way, e_src, e_set, e_mv, e_wr},
            tag, {resp_way, resp_src_way, resp_set, resp_move, resp_write},
            {e_way, e_src, e_set, e_mv, e_wr});
    check(evict_req == m_wait && req_ready == !m_wait, m_wait ? "R11" : "R5",
          {evict_req, req_ready}, {m_wait, !m_wait});
    if (m_wait)
      check({evict_way, evict_set} == {m_evway, m_evset}, "R5", {evict_way, evict_set}, {m_evway, m_evset});
    check(restrict_mask == mask_of(m_rwin), tag, restrict_mask, mask_of(m_rwin));
  endtask

  task automatic idle(bit tk);
    cyc(0, 0, 0, 0, '1, tk, 0);
  endtask

  task automatic wr(logic [3:0] way, int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 10'd7, way, '1, 0, 0);
  endtask

  task automatic run_interval();
    for (int i = 0; i < IVL; i++) idle(1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(restrict_mask == 16'h000F && req_ready && !resp_valid && !evict_req, "R1",
          {restrict_mask, req_ready, resp_valid, evict_req}, {16'h000F, 3'b100});
    // R2: read in barred window served in place
    cyc(1, 0, 10'd3, 4'd2, '1, 0, 0);
    idle(0);
    // R3: write outside the barred window
    cyc(1, 1, 10'd3, 4'd5, '1, 0, 0);
    // R4: only way 2 (barred) and way 9 invalid -> way 9
    cyc(1, 1, 10'd5, 4'd1, 16'hFDFB, 0, 0);
    idle(0);
    check(resp_valid == 0, "R4", resp_valid, 0);
    // R5 + R11: full set, eviction of way 4, requests ignored while pending
    cyc(1, 1, 10'd9, 4'd3, '1, 0, 0);
    cyc(1, 1, 10'd1, 4'd6, '1, 0, 0);
    cyc(1, 0, 10'd1, 4'd8, '1, 0, 0);
    cyc(0, 0, 0, 0, '1, 0, 1);
    check(resp_way == 4'd4 && resp_src_way == 4'd3 && resp_move, "R5",
          {resp_way, resp_src_way, resp_move}, {4'd4, 4'd3, 1'b1});
    idle(0);
    // R6 + R7: rotation through all windows and back to 0
    run_interval();
    check(restrict_mask == 16'h00F0, "R7", restrict_mask, 16'h00F0);
    run_interval(); run_interval(); run_interval();
    check(restrict_mask == 16'h000F, "R7", restrict_mask, 16'h000F);
    // R8: tie between windows 2 and 3 goes to window 2
    mode_dyn = 1;
    wr(4'd9, 1); wr(4'd10, 1); wr(4'd11, 1); wr(4'd13, 3);
    run_interval();
    check(restrict_mask == 16'h0F00, "R8", restrict_mask, 16'h0F00);
    // R9: counts from the previous interval must not carry over
    wr(4'd12, 5);
    run_interval();
    check(restrict_mask == 16'hF000, "R8", restrict_mask, 16'hF000);
    wr(4'd4, 2);
    run_interval();
    check(restrict_mask == 16'h00F0, "R9", restrict_mask, 16'h00F0);
    // R10: window 0 saturates at 15, ties window 2 with 15
    wr(4'd0, 20); wr(4'd8, 15);
    run_interval();
    check(restrict_mask == 16'h000F, "R10", restrict_mask, 16'h000F);
    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] vb;
      vb = ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom | $urandom | $urandom);
      if ($urandom % 64 == 0) mode_dyn = $urandom % 2;
      cyc($urandom % 4 != 0, $urandom % 2, 10'($urandom), 4'($urandom), vb,
          $urandom % 4 == 0, $urandom % 3 == 0);
    end
    finish_run();
  end
endmodule